// File: doc/BRIEF.md
# Addressed Register Bank Behind a Two-Wire Serial Slave

This block lets a bus master reach a small bank of 8-bit registers over a two-wire serial bus (clock line plus open-drain data line). It answers one fixed 7-bit device address. A transfer first loads a register pointer. It then either writes data bytes or, after a repeated start with the read bit set, streams bytes back. The pointer advances by one after every byte moved, so a single transfer can cover consecutive registers.

The bank connects to the surrounding sensor logic through a sample input with a strobe, three event inputs that raise interrupt sources, and the two control registers as outputs. Some reads have side effects. A read of the communication-test register completes a handshake. A read of the sample register clears the overrun flag. A read of the release register clears every latched interrupt. The interrupt pin can be enabled, can be set to either polarity, and can either follow the latched sources or emit a timed pulse.

Bus lines are resynchronised to the system clock, which must run at least eight times the serial clock rate. The block never stretches the clock.

Top module: `i2c_regbank_slave`

## Requirements
- R1: Only an address byte whose upper seven bits equal SLAVE_ADDR (default 0x0F) is acknowledged; bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and the block stays silent until the next start.
- R2: In a write transfer the first byte after the address loads the pointer. Every following data byte is stored at the pointer, and the pointer then increments. Every byte is acknowledged.
- R3: A read is a pointer write, a repeated start, and the address with bit 0 set. Bytes are sent MSB first from consecutive addresses for as long as the master acknowledges; a master NACK ends the stream.
- R4: Only 0x1B (ctrl1, reset 0x00), 0x1D (ctrl3, reset 0x06) and 0x1E (pin control, reset 0x08) can be written. Writes anywhere else are ignored. Addresses with no register read 0x00; 0x1A also reads 0x00.
- R5: Register 0x0C reads 0x55. After ctrl3 bit 4 is set it reads 0xAA. That read clears ctrl3 bit 4, so the next read gives 0x55.
- R6: A pulse on event input k (k = 0..2) latches source bit k when ctrl1 bit k is set. Register 0x16 shows the latched sources in bits 2:0. Status register 0x18 bit 4 is the OR of the sources.
- R7: Reading 0x1A clears all latched sources and status bit 4, and returns the pin to its inactive level.
- R8: Pin control bit 4 enables the pin and bit 3 sets its polarity (1 = active high). A disabled pin sits at the inactive level even while sources are latched.
- R9: When pin control bit 2 is set, each accepted event drives the pin active for PULSE_CYCLES clocks. When it is clear, the pin follows the latched sources.
- R10: Status bit 5 is set when a new sample strobe arrives before the previous sample was read at 0x12. Reading 0x12 returns the newest sample and clears bit 5.
- R11: Writing ctrl3 with bit 7 set starts a soft reset. Bit 7 reads 1 for SRST_CYCLES clocks, after which ctrl1, ctrl3 and pin control return to their reset values.
- R12: The data line is pulled low only in the cycle following a detected clock falling edge, never in response to a rising one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| sample_i | input | 8 | Newest sample from the core |
| sample_stb_i | input | 1 | Sample valid strobe |
| event_i | input | 3 | Interrupt event pulses |
| ctrl1_o | output | 8 | Main control register |
| ctrl3_o | output | 8 | Secondary control register (bit 7 = soft reset busy) |
| int_pin_o | output | 1 | Interrupt pin level |

## Verification
The bench builds the block with SRST_CYCLES = 3000 and PULSE_CYCLES = 40 and keeps the default address. These values let the busy window of the soft reset stay open across a whole readback transfer, so bit 7 can be seen set and later seen cleared. The short pulse lets the pin be sampled both inside and after its active window. Master clock half-periods of 20 system clocks keep the oversampling ratio well above the minimum.

// File: rtl/i2c_rb_pkg.sv
// Shared constants for the register bank slave: register addresses,
// reset values and the transfer state encoding.
package i2c_rb_pkg;
    localparam logic [7:0] A_COMTEST = 8'h0C;
    localparam logic [7:0] A_SAMPLE  = 8'h12;
    localparam logic [7:0] A_SOURCE  = 8'h16;
    localparam logic [7:0] A_STATUS  = 8'h18;
    localparam logic [7:0] A_RELEASE = 8'h1A;
    localparam logic [7:0] A_CTRL1   = 8'h1B;
    localparam logic [7:0] A_CTRL3   = 8'h1D;
    localparam logic [7:0] A_PINCTL  = 8'h1E;

    localparam logic [7:0] RV_CTRL1  = 8'h00;
    localparam logic [6:0] RV_CTRL3  = 7'h06;
    localparam logic [7:0] RV_PINCTL = 8'h08;

    typedef enum logic [2:0] {
        XS_IDLE, XS_ADDR, XS_PTR, XS_WR, XS_RD
    } xfer_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Resynchronises both bus lines and reports clock edges plus start and
// stop conditions. Assumes the system clock is well above the bus rate.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] raw;
    logic [1:0] synced;
    logic       scl_p, sda_p;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // shift the line level through the synchroniser chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    assign scl_s = synced[1];
    assign sda_s = synced[0];

    // keep the previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_xfer_engine.sv
// Bus protocol engine: address match, pointer load, write and read
// streaming with auto-increment. Assumes data changes only while the
// clock is low; drives the data line only after a clock fall.
module i2c_xfer_engine
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_pull_o,
    output logic       wr_en,
    output logic       rd_en,
    output logic [7:0] reg_addr,
    output logic [7:0] wr_data,
    input  logic [7:0] rd_data
);
    xfer_state_t st;
    logic [3:0]  cnt;
    logic [7:0]  sr, tx, ptr;
    logic        rw_q, hit_q, mack_q, pull_q;
    logic        busy_edge;

    assign busy_edge  = scl_fall && !start_det && !stop_det;
    assign wr_en      = busy_edge && cnt == 4'd8 && st == XS_WR;
    assign rd_en      = busy_edge && cnt == 4'd9 &&
                        ((st == XS_ADDR && hit_q && rw_q) || (st == XS_RD && mack_q));
    assign reg_addr   = ptr;
    assign wr_data    = sr;
    assign sda_pull_o = pull_q;

    // frame sequencing, shifting, acknowledge and transmit drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= XS_IDLE; cnt <= '0; sr <= '0; tx <= '0; ptr <= '0;
            rw_q <= 1'b0; hit_q <= 1'b0; mack_q <= 1'b0; pull_q <= 1'b0;
        end else if (start_det) begin
            st <= XS_ADDR; cnt <= '0; pull_q <= 1'b0;
        end else if (stop_det) begin
            st <= XS_IDLE; cnt <= '0; pull_q <= 1'b0;
        end else if (st != XS_IDLE) begin
            if (scl_rise) begin
                cnt <= cnt + 4'd1;
                if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
                if (cnt == 4'd8) mack_q <= ~sda_s;
            end
            if (scl_fall) begin
                if (cnt == 4'd8) begin
                    unique case (st)
                        XS_ADDR: begin
                            hit_q <= (sr[7:1] == SLAVE_ADDR);
                            rw_q  <= sr[0];
                            pull_q <= (sr[7:1] == SLAVE_ADDR);
                        end
                        XS_PTR:  begin pull_q <= 1'b1; ptr <= sr; end
                        XS_WR:   begin pull_q <= 1'b1; ptr <= ptr + 8'd1; end
                        default: pull_q <= 1'b0;
                    endcase
                end else if (cnt == 4'd9) begin
                    cnt    <= '0;
                    pull_q <= 1'b0;
                    unique case (st)
                        XS_ADDR: begin
                            if (!hit_q) st <= XS_IDLE;
                            else if (rw_q) begin
                                st <= XS_RD; tx <= rd_data; ptr <= ptr + 8'd1;
                                pull_q <= ~rd_data[7];
                            end else st <= XS_PTR;
                        end
                        XS_PTR: st <= XS_WR;
                        XS_RD: begin
                            if (mack_q) begin
                                tx <= rd_data; ptr <= ptr + 8'd1;
                                pull_q <= ~rd_data[7];
                            end else st <= XS_IDLE;
                        end
                        default: st <= st;
                    endcase
                end else if (st == XS_RD && cnt != 4'd0) begin
                    pull_q <= ~tx[3'd7 - cnt[2:0]];
                end
            end
        end
    end

    // R12
    pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> $past(scl_fall));

    // R1
    no_ack_foreign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_edge && cnt == 4'd8 && st == XS_ADDR && sr[7:1] != SLAVE_ADDR) |=> !sda_pull_o);
endmodule

// File: rtl/i2c_reg_file.sv
// Register bank with read side effects, interrupt latching, pin shaping
// and timed soft reset. Assumes at most one access per cycle.
module i2c_reg_file
    import i2c_rb_pkg::*;
#(
    parameter int SRST_CYCLES  = 12_500_000,
    parameter int PULSE_CYCLES = 12_500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic [7:0] sample_i,
    input  logic       sample_stb_i,
    input  logic [2:0] event_i,
    output logic [7:0] ctrl1_o,
    output logic [7:0] ctrl3_o,
    output logic       int_pin_o
);
    localparam int SW = $clog2(SRST_CYCLES + 1);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [7:0]    ctrl1_q, pinctl_q, sample_q;
    logic [6:0]    ctrl3_q;
    logic [2:0]    src_q, accepted;
    logic          ovr_q, fresh_q, srst_busy, active;
    logic [SW-1:0] srst_cnt;
    logic [PW-1:0] pulse_cnt;
    logic          rd_rel, rd_ct, rd_smp;

    assign srst_busy = (srst_cnt != '0);
    assign accepted  = event_i & ctrl1_q[2:0];
    assign rd_rel    = rd_en && reg_addr == A_RELEASE;
    assign rd_ct     = rd_en && reg_addr == A_COMTEST;
    assign rd_smp    = rd_en && reg_addr == A_SAMPLE;
    assign ctrl1_o   = ctrl1_q;
    assign ctrl3_o   = {srst_busy, ctrl3_q};

    // read data selection
    always_comb begin
        unique case (reg_addr)
            A_COMTEST: rd_data = ctrl3_q[4] ? 8'hAA : 8'h55;
            A_SAMPLE:  rd_data = sample_q;
            A_SOURCE:  rd_data = {5'b0, src_q};
            A_STATUS:  rd_data = {2'b0, ovr_q, |src_q, 4'b0};
            A_CTRL1:   rd_data = ctrl1_q;
            A_CTRL3:   rd_data = {srst_busy, ctrl3_q};
            A_PINCTL:  rd_data = pinctl_q;
            default:   rd_data = 8'h00;
        endcase
    end

    // control registers, soft reset timer and test handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl1_q <= RV_CTRL1; ctrl3_q <= RV_CTRL3; pinctl_q <= RV_PINCTL;
            srst_cnt <= '0;
        end else if (srst_cnt == SW'(1)) begin
            ctrl1_q <= RV_CTRL1; ctrl3_q <= RV_CTRL3; pinctl_q <= RV_PINCTL;
            srst_cnt <= '0;
        end else begin
            if (srst_busy) srst_cnt <= srst_cnt - SW'(1);
            if (wr_en) begin
                unique case (reg_addr)
                    A_CTRL1:  ctrl1_q <= wr_data;
                    A_PINCTL: pinctl_q <= wr_data;
                    A_CTRL3: begin
                        ctrl3_q <= wr_data[6:0];
                        if (wr_data[7] && !srst_busy) srst_cnt <= SW'(SRST_CYCLES);
                    end
                    default: ;
                endcase
            end
            if (rd_ct) ctrl3_q[4] <= 1'b0;
        end
    end

    // sample capture and overrun tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0; ovr_q <= 1'b0; fresh_q <= 1'b0;
        end else if (sample_stb_i) begin
            sample_q <= sample_i;
            fresh_q  <= 1'b1;
            if (fresh_q && !rd_smp) ovr_q <= 1'b1;
            else if (rd_smp) ovr_q <= 1'b0;
        end else if (rd_smp) begin
            fresh_q <= 1'b0; ovr_q <= 1'b0;
        end
    end

    // interrupt source latch and pulse timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0; pulse_cnt <= '0;
        end else begin
            src_q <= (rd_rel ? 3'b000 : src_q) | accepted;
            if (|accepted && pinctl_q[2]) pulse_cnt <= PW'(PULSE_CYCLES);
            else if (rd_rel)              pulse_cnt <= '0;
            else if (pulse_cnt != '0)     pulse_cnt <= pulse_cnt - PW'(1);
        end
    end

    assign active    = pinctl_q[2] ? (pulse_cnt != '0) : (|src_q);
    assign int_pin_o = pinctl_q[4] ? (pinctl_q[3] ? active : ~active) : ~pinctl_q[3];

    // R7
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rel && accepted == 3'b000) |=> src_q == 3'b000);

    // R5
    comtest_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ct |=> !ctrl3_q[4]);

    // R10
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_smp && !sample_stb_i) |=> !ovr_q);

    // R11
    srst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srst_busy) |-> (ctrl1_q == RV_CTRL1 && ctrl3_q == RV_CTRL3 && pinctl_q == RV_PINCTL));
endmodule

// File: rtl/i2c_regbank_slave.sv
// Top level: line synchroniser, protocol engine and register bank.
// Assumes an open-drain data line where sda_pull_o pulls it low.
module i2c_regbank_slave #(
    parameter logic [6:0] SLAVE_ADDR   = 7'h0F,
    parameter int         SYNC_STAGES  = 2,
    parameter int         SRST_CYCLES  = 12_500_000,
    parameter int         PULSE_CYCLES = 12_500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [7:0] sample_i,
    input  logic       sample_stb_i,
    input  logic [2:0] event_i,
    output logic [7:0] ctrl1_o,
    output logic [7:0] ctrl3_o,
    output logic       int_pin_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_en, rd_en;
    logic [7:0] reg_addr, wr_data, rd_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_xfer_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_pull_o(sda_pull_o), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    i2c_reg_file #(.SRST_CYCLES(SRST_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .sample_i(sample_i), .sample_stb_i(sample_stb_i), .event_i(event_i),
        .ctrl1_o(ctrl1_o), .ctrl3_o(ctrl3_o), .int_pin_o(int_pin_o)
    );
endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
    localparam int H = 20;
    localparam logic [6:0] DEV = 7'h0F;
    localparam int PULSE = 40;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_line, sda_pull, int_pin, sample_stb = 1'b0;
    logic [7:0] sample = '0, ctrl1, ctrl3;
    logic [2:0] ev = '0;
    int checks = 0, errors = 0;
    logic ack_fail;
    logic [7:0] rbuf [4];

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    i2c_regbank_slave #(.SRST_CYCLES(3000), .PULSE_CYCLES(PULSE)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .sample_i(sample), .sample_stb_i(sample_stb),
        .event_i(ev), .ctrl1_o(ctrl1), .ctrl3_o(ctrl3), .int_pin_o(int_pin)
    );

    function automatic logic [7:0] status_exp(input logic ovr, input logic irq);
        return {2'b0, ovr, irq, 4'b0};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic hw; repeat (H) @(negedge clk); endtask
    task automatic bstart; m_sda = 1; m_scl = 1; hw; m_sda = 0; hw; m_scl = 0; hw; endtask
    task automatic brstart; m_sda = 1; hw; m_scl = 1; hw; m_sda = 0; hw; m_scl = 0; hw; endtask
    task automatic bstop; m_sda = 0; hw; m_scl = 1; hw; m_sda = 1; hw; endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw; m_scl = 1; hw; m_scl = 0;
        end
        m_sda = 1; hw; m_scl = 1; hw; ack = ~sda_line; m_scl = 0; hw;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            hw; m_scl = 1; hw; b[i] = sda_line; m_scl = 0;
        end
        m_sda = ~give_ack; hw; m_scl = 1; hw; m_scl = 0; hw; m_sda = 1;
    endtask

    task automatic wr_regs(input logic [7:0] a, input int n,
                           input logic [7:0] d0, d1, d2, d3);
        logic ak;
        logic [7:0] d [4];
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        ack_fail = 0;
        bstart; wbyte({DEV, 1'b0}, ak); ack_fail |= ~ak;
        wbyte(a, ak); ack_fail |= ~ak;
        for (int k = 0; k < n; k++) begin wbyte(d[k], ak); ack_fail |= ~ak; end
        bstop;
    endtask

    task automatic rd_regs(input logic [7:0] a, input int n);
        logic ak;
        logic [7:0] b;
        ack_fail = 0;
        bstart; wbyte({DEV, 1'b0}, ak); ack_fail |= ~ak;
        wbyte(a, ak); ack_fail |= ~ak;
        brstart; wbyte({DEV, 1'b1}, ak); ack_fail |= ~ak;
        for (int k = 0; k < n; k++) begin rbyte(k < n - 1, b); rbuf[k] = b; end
        bstop;
    endtask

    task automatic pulse_event(input logic [2:0] e);
        @(negedge clk); ev = e; @(negedge clk); ev = '0; repeat (4) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] v);
        @(negedge clk); sample = v; sample_stb = 1; @(negedge clk); sample_stb = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] v;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);

        // reset state (R8, R4, R5)
        check("R8 reset pin", {7'b0, int_pin}, 8'h00);
        check("R12 reset release", {7'b0, sda_pull}, 8'h00);
        rd_regs(8'h1D, 2);
        check("R4 ctrl3 reset", rbuf[0], 8'h06);
        check("R8 pinctl reset", rbuf[1], 8'h08);
        check("R3 read acks", {7'b0, ack_fail}, 8'h00);
        rd_regs(8'h0C, 1);
        check("R5 comtest idle", rbuf[0], 8'h55);

        // R1: foreign addresses get no acknowledge
        for (int i = 0; i < 6; i++) begin
            v = 8'($urandom % 128);
            if (v[6:0] == DEV) v = 8'h21;
            bstart; wbyte({v[6:0], 1'($urandom % 2)}, ak); bstop;
            check("R1 foreign nack", {7'b0, ak}, 8'h00);
        end

        // R2 R4: multi-byte write across a hole
        wr_regs(8'h1B, 4, 8'h01, 8'h77, 8'h06, 8'h18);
        check("R2 write acks", {7'b0, ack_fail}, 8'h00);
        rd_regs(8'h1B, 4);
        check("R2 ctrl1", rbuf[0], 8'h01);
        check("R4 hole reads zero", rbuf[1], 8'h00);
        check("R2 ctrl3", rbuf[2], 8'h06);
        check("R2 pinctl", rbuf[3], 8'h18);
        wr_regs(8'h0C, 1, 8'h99, 0, 0, 0);
        rd_regs(8'h0C, 1);
        check("R4 read-only ignored", rbuf[0], 8'h55);

        // R6 R7: latched interrupt, active high
        pulse_event(3'b011);
        check("R6 pin latched", {7'b0, int_pin}, 8'h01);
        rd_regs(8'h16, 3);
        check("R6 source bits", rbuf[0], 8'h01);
        check("R3 increment hole", rbuf[1], 8'h00);
        check("R6 status int", rbuf[2], status_exp(0, 1));
        rd_regs(8'h1A, 1);
        check("R7 release reads zero", rbuf[0], 8'h00);
        check("R7 pin cleared", {7'b0, int_pin}, 8'h00);
        rd_regs(8'h18, 1);
        check("R7 status cleared", rbuf[0], status_exp(0, 0));

        // R8: active low and disabled pin
        wr_regs(8'h1E, 1, 8'h10, 0, 0, 0);
        check("R8 low idle", {7'b0, int_pin}, 8'h01);
        pulse_event(3'b001);
        check("R8 low active", {7'b0, int_pin}, 8'h00);
        rd_regs(8'h1A, 1);
        check("R7 low released", {7'b0, int_pin}, 8'h01);
        wr_regs(8'h1E, 1, 8'h08, 0, 0, 0);
        pulse_event(3'b001);
        check("R8 disabled pin", {7'b0, int_pin}, 8'h00);
        rd_regs(8'h18, 1);
        check("R8 disabled still latched", rbuf[0], status_exp(0, 1));
        rd_regs(8'h1A, 1);

        // R9: pulse mode
        wr_regs(8'h1E, 1, 8'h1C, 0, 0, 0);
        pulse_event(3'b001);
        repeat (10) @(negedge clk);
        check("R9 pulse active", {7'b0, int_pin}, 8'h01);
        repeat (PULSE) @(negedge clk);
        check("R9 pulse ended", {7'b0, int_pin}, 8'h00);
        rd_regs(8'h1A, 1);

        // R10: overrun
        strobe(8'h11);
        rd_regs(8'h18, 1);
        check("R10 single no overrun", rbuf[0], status_exp(0, 0));
        strobe(8'hA5); strobe(8'h3C);
        rd_regs(8'h18, 1);
        check("R10 overrun set", rbuf[0], status_exp(1, 0));
        rd_regs(8'h12, 1);
        check("R10 newest sample", rbuf[0], 8'h3C);
        rd_regs(8'h18, 1);
        check("R10 overrun cleared", rbuf[0], status_exp(0, 0));

        // R5: handshake
        wr_regs(8'h1D, 1, 8'h16, 0, 0, 0);
        rd_regs(8'h0C, 1);
        check("R5 comtest armed", rbuf[0], 8'hAA);
        rd_regs(8'h0C, 1);
        check("R5 comtest restored", rbuf[0], 8'h55);
        rd_regs(8'h1D, 1);
        check("R5 ctc cleared", rbuf[0], 8'h06);

        // R2: random single writes with readback
        for (int i = 0; i < 8; i++) begin
            v = 8'($urandom);
            wr_regs(8'h1B, 1, v, 0, 0, 0);
            rd_regs(8'h1B, 1);
            check("R2 random ctrl1", rbuf[0], v);
        end

        // R11: soft reset
        wr_regs(8'h1B, 1, 8'h5A, 0, 0, 0);
        wr_regs(8'h1D, 1, 8'h81, 0, 0, 0);
        rd_regs(8'h1D, 1);
        check("R11 busy bit", rbuf[0] & 8'h80, 8'h80);
        repeat (3000) @(negedge clk);
        rd_regs(8'h1B, 4);
        check("R11 ctrl1 reload", rbuf[0], 8'h00);
        check("R11 ctrl3 reload", rbuf[2], 8'h06);
        check("R11 pinctl reload", rbuf[3], 8'h08);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule